// File: doc/BRIEF.md
# Paged Address Translation Unit with Associative Cache

This block turns a logical address into a physical address for paged memory. The upper bits of the logical address select a page and the lower bits give a byte offset. The offset passes through unchanged. The page is mapped to a frame, and the physical address is that frame with the offset appended.

A small fully associative translation cache is searched first. A hit answers in one cycle. On a miss the block reads its own page table, which holds a frame number and a valid flag for each page. A valid result is written into the cache and returned. A page at or beyond the programmed table length is illegal. A table entry whose valid flag is clear is absent. Both cases raise a fault in place of a translation, and a fault never enters the cache.

Software loads the table and the length limit through a configuration port. It can clear the whole cache with a one-cycle flush. One request is in flight at a time: `ready_o` is high whenever a new request may be issued.

Top module: `page_xlat_unit`

## Requirements
- R1: A successful translation returns `paddr_o` = {frame, offset}, where the offset is bits [OFF_W-1:0] of `vaddr_i` and the page is bits [VA_W-1:OFF_W].
- R2: A request accepted while its page is cached gives `done_o`=1 and `hit_o`=1 in the cycle after acceptance, without reading the table.
- R3: A request that misses the cache gives `done_o` three cycles after acceptance, with `ready_o` low for the two cycles in between.
- R4: A miss on a valid table entry inserts that page into the cache, so the next request to the page hits. The cache never holds two entries for one page.
- R5: A page number greater than or equal to the length register faults in the cycle after acceptance, with `hit_o`=0 and `paddr_o`=0. This holds even if the page is cached.
- R6: A miss whose table entry has the valid flag clear ends with `done_o`=1, `fault_o`=1, `hit_o`=0 and `paddr_o`=0.
- R7: A faulting translation is never inserted into the cache, so repeating it takes the miss latency again.
- R8: A fill uses the lowest-numbered empty cache slot. When all slots are occupied, it replaces the slot named by a round-robin pointer. The pointer starts at slot 0 after reset and advances by one, wrapping, on each replacement.
- R9: `flush_i` empties the whole cache in one cycle, and a flush takes precedence over a fill in the same cycle.
- R10: A table write through `cfg_pte_we_i` also drops any cache entry for that page, so the next request to it misses and returns the new contents.
- R11: After reset, `ready_o`=1, `done_o`=0, `fault_o`=0, the cache is empty, every table entry is invalid and the length register is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Empty the translation cache |
| req_i | input | 1 | Translation request, taken when `ready_o` is high |
| vaddr_i | input | VA_W | Logical address (page, offset) |
| ready_o | output | 1 | Unit idle and able to accept a request |
| done_o | output | 1 | One-cycle result strobe |
| paddr_o | output | PA_W | Physical address (frame, offset) |
| fault_o | output | 1 | Result is a page fault |
| hit_o | output | 1 | Result came from the cache |
| cfg_pte_we_i | input | 1 | Write one page table entry |
| cfg_pte_idx_i | input | PAGE_W | Page index of the entry written |
| cfg_pte_frame_i | input | FRAME_W | Frame number to store |
| cfg_pte_valid_i | input | 1 | Valid flag to store |
| cfg_len_we_i | input | 1 | Write the table length register |
| cfg_len_i | input | PAGE_W+1 | New table length in pages |

## Verification
Several properties are checked on every cycle by the assertions:
- the cache never matches one page twice;
- a flush leaves it empty;
- a filled entry is never a faulting result;
- an out-of-range page faults at once;
- the miss path has a fixed length;
- a hit carries its offset through.

Other behaviour needs history across many requests, so only the bench scenarios can show it. This covers replacement order, since slot choice and the round-robin pointer show up only as later hit or miss latencies. It also covers cache invalidation on table writes, and the rule that faults stay uncached. The bench sweeps every page against a running model of the cache, the table and the length limit.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_FILL = 2'd2
  } walk_state_e;
endpackage

// File: rtl/ptw_table.sv
module ptw_table #(
  parameter int PAGE_W  = 4,
  parameter int FRAME_W = 6,
  parameter int LEN_W   = PAGE_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               we_i,
  input  logic [PAGE_W-1:0]  widx_i,
  input  logic [FRAME_W-1:0] wframe_i,
  input  logic               wvalid_i,
  input  logic               len_we_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic               rd_en_i,
  input  logic [PAGE_W-1:0]  ridx_i,
  output logic               rd_valid_o,
  output logic [FRAME_W-1:0] rd_frame_o,
  output logic [LEN_W-1:0]   len_o
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [DEPTH-1:0]   valid_q;
  logic [FRAME_W-1:0] frame_q [DEPTH];
  logic [LEN_W-1:0]   len_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < DEPTH; i++) frame_q[i] <= '0;
    end else if (we_i) begin
      valid_q[widx_i] <= wvalid_i;
      frame_q[widx_i] <= wframe_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        len_q <= '0;
    else if (len_we_i)  len_q <= len_i;
  end

  // write-through so a same-cycle write is never missed by a walk
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_frame_o <= '0;
    end else if (rd_en_i) begin
      if (we_i && (widx_i == ridx_i)) begin
        rd_valid_o <= wvalid_i;
        rd_frame_o <= wframe_i;
      end else begin
        rd_valid_o <= valid_q[ridx_i];
        rd_frame_o <= frame_q[ridx_i];
      end
    end
  end

  assign len_o = len_q;
endmodule

// File: rtl/rr_victim.sv
module rr_victim #(
  parameter int N     = 8,
  parameter int IDX_W = $clog2(N)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     valid_i,
  input  logic             adv_i,
  output logic [IDX_W-1:0] victim_o
);
  logic [IDX_W-1:0] rr_q;
  logic             found;
  logic             full;

  assign full = &valid_i;

  always_comb begin
    victim_o = rr_q;
    found    = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (!found && !valid_i[i]) begin
        victim_o = IDX_W'(i);
        found    = 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (adv_i && full)
      rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
  end
endmodule

// File: rtl/tlb_cam.sv
module tlb_cam #(
  parameter int N       = 8,
  parameter int PAGE_W  = 4,
  parameter int FRAME_W = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic [PAGE_W-1:0]  look_page_i,
  output logic               hit_o,
  output logic [FRAME_W-1:0] hit_frame_o,
  output logic [N-1:0]       match_o,
  output logic [N-1:0]       valid_o,
  input  logic               fill_i,
  input  logic [PAGE_W-1:0]  fill_page_i,
  input  logic [FRAME_W-1:0] fill_frame_i,
  input  logic               inv_i,
  input  logic [PAGE_W-1:0]  inv_page_i
);
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1;

  logic [N-1:0]       valid_q;
  logic [PAGE_W-1:0]  tag_q   [N];
  logic [FRAME_W-1:0] frame_q [N];
  logic [IDX_W-1:0]   victim;

  rr_victim #(.N(N), .IDX_W(IDX_W)) u_victim (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (valid_q),
    .adv_i    (fill_i),
    .victim_o (victim)
  );

  for (genvar g = 0; g < N; g++) begin : g_match
    assign match_o[g] = valid_q[g] && (tag_q[g] == look_page_i);
  end

  always_comb begin
    hit_frame_o = '0;
    for (int i = 0; i < N; i++)
      if (match_o[i]) hit_frame_o = hit_frame_o | frame_q[i];
  end

  assign hit_o   = |match_o;
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
      for (int i = 0; i < N; i++) begin
        tag_q[i]   <= '0;
        frame_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < N; i++) begin
        if (flush_i) begin
          valid_q[i] <= 1'b0;
        end else if (fill_i && (victim == IDX_W'(i))) begin
          valid_q[i] <= 1'b1;
          tag_q[i]   <= fill_page_i;
          frame_q[i] <= fill_frame_i;
        end else if (inv_i && valid_q[i] && (tag_q[i] == inv_page_i)) begin
          valid_q[i] <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/page_xlat_unit.sv
module page_xlat_unit #(
  parameter int PAGE_W  = 4,
  parameter int OFF_W   = 8,
  parameter int FRAME_W = 6,
  parameter int TLB_N   = 8,
  localparam int VA_W   = PAGE_W + OFF_W,
  localparam int PA_W   = FRAME_W + OFF_W,
  localparam int LEN_W  = PAGE_W + 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               flush_i,
  input  logic               req_i,
  input  logic [VA_W-1:0]    vaddr_i,
  output logic               ready_o,
  output logic               done_o,
  output logic [PA_W-1:0]    paddr_o,
  output logic               fault_o,
  output logic               hit_o,
  input  logic               cfg_pte_we_i,
  input  logic [PAGE_W-1:0]  cfg_pte_idx_i,
  input  logic [FRAME_W-1:0] cfg_pte_frame_i,
  input  logic               cfg_pte_valid_i,
  input  logic               cfg_len_we_i,
  input  logic [LEN_W-1:0]   cfg_len_i
);
  import xlat_pkg::*;

  walk_state_e        state_q;
  logic [PAGE_W-1:0]  pg_q;
  logic [OFF_W-1:0]   off_q;
  logic               done_q, fault_q, hit_q;
  logic [PA_W-1:0]    paddr_q;

  logic [PAGE_W-1:0]  page_in;
  logic [OFF_W-1:0]   off_in;
  logic               accept, out_of_range;
  logic               tlb_hit;
  logic [FRAME_W-1:0] tlb_frame;
  logic [TLB_N-1:0]   tlb_match, tlb_valid;
  logic               pte_valid;
  logic [FRAME_W-1:0] pte_frame;
  logic [LEN_W-1:0]   len_q;
  logic               fill_en;

  assign page_in      = vaddr_i[VA_W-1:OFF_W];
  assign off_in       = vaddr_i[OFF_W-1:0];
  assign accept       = req_i && (state_q == ST_IDLE);
  assign out_of_range = ({1'b0, page_in} >= len_q);
  // a flush or a same-page table write in the fill cycle cancels the insert
  assign fill_en      = (state_q == ST_FILL) && pte_valid && !flush_i &&
                        !(cfg_pte_we_i && (cfg_pte_idx_i == pg_q));

  ptw_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_table (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .we_i       (cfg_pte_we_i),
    .widx_i     (cfg_pte_idx_i),
    .wframe_i   (cfg_pte_frame_i),
    .wvalid_i   (cfg_pte_valid_i),
    .len_we_i   (cfg_len_we_i),
    .len_i      (cfg_len_i),
    .rd_en_i    (state_q == ST_READ),
    .ridx_i     (pg_q),
    .rd_valid_o (pte_valid),
    .rd_frame_o (pte_frame),
    .len_o      (len_q)
  );

  tlb_cam #(.N(TLB_N), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_tlb (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .flush_i      (flush_i),
    .look_page_i  (page_in),
    .hit_o        (tlb_hit),
    .hit_frame_o  (tlb_frame),
    .match_o      (tlb_match),
    .valid_o      (tlb_valid),
    .fill_i       (fill_en),
    .fill_page_i  (pg_q),
    .fill_frame_i (pte_frame),
    .inv_i        (cfg_pte_we_i),
    .inv_page_i   (cfg_pte_idx_i)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      pg_q    <= '0;
      off_q   <= '0;
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      hit_q   <= 1'b0;
      paddr_q <= '0;
    end else begin
      done_q  <= 1'b0;
      fault_q <= 1'b0;
      hit_q   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (out_of_range) begin
              done_q  <= 1'b1;
              fault_q <= 1'b1;
              paddr_q <= '0;
            end else if (tlb_hit) begin
              done_q  <= 1'b1;
              hit_q   <= 1'b1;
              paddr_q <= {tlb_frame, off_in};
            end else begin
              pg_q    <= page_in;
              off_q   <= off_in;
              state_q <= ST_READ;
            end
          end
        end
        ST_READ: state_q <= ST_FILL;
        ST_FILL: begin
          done_q  <= 1'b1;
          fault_q <= !pte_valid;
          paddr_q <= pte_valid ? {pte_frame, off_q} : '0;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign ready_o = (state_q == ST_IDLE);
  assign done_o  = done_q;
  assign fault_o = fault_q;
  assign hit_o   = hit_q;
  assign paddr_o = paddr_q;
endmodule

// File: rtl/page_xlat_chk.sv
module page_xlat_chk #(
  parameter int PAGE_W = 4,
  parameter int OFF_W  = 8,
  parameter int TLB_N  = 8,
  localparam int VA_W  = PAGE_W + OFF_W,
  localparam int LEN_W = PAGE_W + 1
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             flush_i,
  input logic             req_i,
  input logic [VA_W-1:0]  vaddr_i,
  input logic             ready_o,
  input logic             done_o,
  input logic             fault_o,
  input logic             hit_o,
  input logic [OFF_W-1:0] paddr_off_i,
  input logic [LEN_W-1:0] len_i,
  input logic [TLB_N-1:0] tlb_valid_i,
  input logic [TLB_N-1:0] tlb_match_i,
  input logic             fill_i
);
  AST_HIT_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hit_o) |-> (paddr_off_i == $past(vaddr_i[OFF_W-1:0]))); // R1

  AST_MISS_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ready_o) |=> (!ready_o ##1 (ready_o && done_o))); // R3

  AST_SINGLE_MATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(tlb_match_i)); // R4

  AST_RANGE_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && req_i && ({1'b0, vaddr_i[VA_W-1:OFF_W]} >= len_i))
      |=> (done_o && fault_o && !hit_o)); // R5

  AST_FAULT_NOT_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |-> (done_o && !hit_o)); // R6

  AST_FILL_NOT_FAULT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(fill_i) |-> (done_o && !fault_o)); // R7

  AST_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(flush_i) |-> (tlb_valid_i == '0)); // R9
endmodule

bind page_xlat_unit page_xlat_chk #(
  .PAGE_W (PAGE_W),
  .OFF_W  (OFF_W),
  .TLB_N  (TLB_N)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .flush_i     (flush_i),
  .req_i       (req_i),
  .vaddr_i     (vaddr_i),
  .ready_o     (ready_o),
  .done_o      (done_o),
  .fault_o     (fault_o),
  .hit_o       (hit_o),
  .paddr_off_i (paddr_o[OFF_W-1:0]),
  .len_i       (len_q),
  .tlb_valid_i (tlb_valid),
  .tlb_match_i (tlb_match),
  .fill_i      (fill_en)
);

// File: tb/page_xlat_unit_bench.sv
module page_xlat_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int PAGE_W  = 4;
  localparam int OFF_W   = 8;
  localparam int FRAME_W = 6;
  localparam int TLB_N   = 8;
  localparam int VA_W    = PAGE_W + OFF_W;
  localparam int PA_W    = FRAME_W + OFF_W;
  localparam int LEN_W   = PAGE_W + 1;
  localparam int NPG     = 1 << PAGE_W;

  logic               clk = 1'b0;
  logic               rst_ni = 1'b0;
  logic               flush_i = 1'b0;
  logic               req_i = 1'b0;
  logic [VA_W-1:0]    vaddr_i = '0;
  logic               ready_o, done_o, fault_o, hit_o;
  logic [PA_W-1:0]    paddr_o;
  logic               cfg_pte_we_i = 1'b0;
  logic [PAGE_W-1:0]  cfg_pte_idx_i = '0;
  logic [FRAME_W-1:0] cfg_pte_frame_i = '0;
  logic               cfg_pte_valid_i = 1'b0;
  logic               cfg_len_we_i = 1'b0;
  logic [LEN_W-1:0]   cfg_len_i = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  page_xlat_unit #(.PAGE_W(PAGE_W), .OFF_W(OFF_W), .FRAME_W(FRAME_W), .TLB_N(TLB_N))
  u_page_xlat_unit (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush_i), .req_i(req_i), .vaddr_i(vaddr_i),
    .ready_o(ready_o), .done_o(done_o), .paddr_o(paddr_o), .fault_o(fault_o), .hit_o(hit_o),
    .cfg_pte_we_i(cfg_pte_we_i), .cfg_pte_idx_i(cfg_pte_idx_i),
    .cfg_pte_frame_i(cfg_pte_frame_i), .cfg_pte_valid_i(cfg_pte_valid_i),
    .cfg_len_we_i(cfg_len_we_i), .cfg_len_i(cfg_len_i)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference model
  bit mval [NPG];
  int mfrm [NPG];
  int mlen = 0;
  bit tval [TLB_N];
  int ttag [TLB_N];
  int trr = 0;

  task automatic check_eq(input string req, input string ctx, input string what,
                          input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s [%s] %s actual=%0d expected=%0d", req, ctx, what, act, exp);
    end
  endtask

  task automatic cfg_pte(input int p, input bit v, input int f);
    @(negedge clk);
    cfg_pte_we_i = 1'b1; cfg_pte_idx_i = PAGE_W'(p);
    cfg_pte_valid_i = v; cfg_pte_frame_i = FRAME_W'(f);
    @(negedge clk);
    cfg_pte_we_i = 1'b0;
    mval[p] = v; mfrm[p] = f;
    for (int s = 0; s < TLB_N; s++) if (tval[s] && ttag[s] == p) tval[s] = 0;
  endtask

  task automatic cfg_len(input int l);
    @(negedge clk);
    cfg_len_we_i = 1'b1; cfg_len_i = LEN_W'(l);
    @(negedge clk);
    cfg_len_we_i = 1'b0;
    mlen = l;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush_i = 1'b1;
    @(negedge clk);
    flush_i = 1'b0;
    for (int s = 0; s < TLB_N; s++) tval[s] = 0;
  endtask

  task automatic xlate(input int p, input int off, input string ctx);
    int lat, cyc, exp_pa, victim;
    bit ef, eh, full;
    eh = 0; ef = 0; exp_pa = 0;
    if (p >= mlen) begin
      lat = 1; ef = 1;
    end else begin
      for (int s = 0; s < TLB_N; s++) if (tval[s] && ttag[s] == p) eh = 1;
      if (eh) begin
        lat = 1; exp_pa = (mfrm[p] << OFF_W) | off;
      end else begin
        lat = 3;
        if (mval[p]) begin
          exp_pa = (mfrm[p] << OFF_W) | off;
          victim = -1; full = 1;
          for (int s = 0; s < TLB_N; s++)
            if (!tval[s] && victim < 0) begin victim = s; full = 0; end
          if (full) begin victim = trr; trr = (trr + 1) % TLB_N; end
          tval[victim] = 1; ttag[victim] = p;
        end else ef = 1;
      end
    end
    @(negedge clk);
    req_i = 1'b1; vaddr_i = VA_W'((p << OFF_W) | off);
    @(negedge clk);
    req_i = 1'b0;
    cyc = 1;
    if (lat == 3) check_eq("R3", ctx, "ready_o during walk", int'(ready_o), 0);
    while (!done_o && cyc < 8) begin
      @(negedge clk);
      cyc++;
    end
    if (eh || (lat == 1)) check_eq("R2", ctx, "latency", cyc, lat);
    else check_eq("R3", ctx, "latency", cyc, lat);
    if (lat == 1 && ef) check_eq("R5", ctx, "range fault", int'(fault_o), 1);
    else if (ef) check_eq("R6", ctx, "invalid fault", int'(fault_o), 1);
    else check_eq("R4", ctx, "fault_o", int'(fault_o), 0);
    check_eq("R2", ctx, "hit_o", int'(hit_o), int'(eh));
    check_eq("R1", ctx, "paddr_o", int'(paddr_o), exp_pa);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NPG; p++) begin mval[p] = 0; mfrm[p] = 0; end
    for (int s = 0; s < TLB_N; s++) begin tval[s] = 0; ttag[s] = 0; end
    repeat (3) @(negedge clk);
    // R11 reset state
    check_eq("R11", "reset", "ready_o", int'(ready_o), 1);
    check_eq("R11", "reset", "done_o", int'(done_o), 0);
    check_eq("R11", "reset", "fault_o", int'(fault_o), 0);
    rst_ni = 1'b1;
    xlate(0, 5, "R11 len zero");
    cfg_len(12);
    xlate(1, 9, "R11 table empty");

    for (int p = 0; p < NPG; p++) cfg_pte(p, (p % 3) != 2, (p * 5 + 3) % 64);

    // full sweep: valid pages fill all slots, invalid and out of range fault
    for (int p = 0; p < NPG; p++)
      for (int r = 0; r < 2; r++) xlate(p, (p * 37 + r * 101) & 255, "R4 R7 sweep");

    // R8 replacement once every slot is occupied
    cfg_len(16);
    xlate(12, 17, "R8 evict slot0");
    xlate(1, 3, "R8 survivor");
    xlate(0, 4, "R8 evicted page");
    xlate(1, 6, "R8 evicted next");
    for (int p = NPG - 1; p >= 0; p--)
      for (int r = 0; r < 2; r++) xlate(p, (p * 11 + r * 53) & 255, "R8 reverse sweep");

    // R10 table write drops cached entry
    xlate(12, 1, "R10 warm");
    cfg_pte(12, 1, 50);
    xlate(12, 2, "R10 new frame");
    xlate(12, 3, "R10 refilled");
    cfg_pte(13, 0, 0);
    xlate(13, 4, "R10 now invalid");

    // R9 flush
    xlate(4, 7, "R9 warm");
    do_flush();
    xlate(4, 8, "R9 after flush");
    xlate(6, 9, "R9 after flush");
    xlate(4, 10, "R9 refilled");

    // R5 range check beats a cached entry
    cfg_len(4);
    xlate(4, 11, "R5 cached but out of range");
    xlate(3, 12, "R5 in range");

    // offset sweep over the remaining pages
    for (int o = 0; o < 256; o++) xlate(o % 5, o, "R1 offset sweep");

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule